// File: doc/BRIEF.md
# Complementary PWM Output Stage

This block sits after the compare logic of one timer channel. It turns a single reference waveform into a pair of complementary pin levels, a main output and a complementary output, each with its own output enable. Each output has its own polarity bit. When both outputs are enabled, a programmable dead-time keeps the two from ever being active together. A set of control bits chooses among disabled, off-state, polarity-only and dead-time mappings. Those bits are a main enable, an off-state select for the running state, an off-state select for the idle state, two channel enables, two polarity bits and two idle-level bits.

A master output enable is held inside the block. Software sets or clears it with a synchronous write. An active-high break input clears it at once, without waiting for a clock edge. While the master enable is low and the idle off-state select is set, both outputs are driven immediately to their inactive (polarity) levels. Once a dead-time has elapsed on the clock, each output moves to its programmed idle level. A level is "active" when it differs from that output's polarity bit: a polarity bit of 0 means active high, and 1 means active low.

Top module: `cpwm_out_stage`

## Requirements
- R1: With the master enable high and both channel enables low, both output enables are 0. Each level is 0 when the run off-state select is 0, and equals its polarity bit when that select is 1.
- R2: With the master enable high and exactly one channel enable set, the enabled output equals the reference XOR its polarity bit, with its enable at 1. The other output has enable 0 and level 0 when the run off-state select is 0. When that select is 1, the other output has enable 1 and a level equal to its own polarity bit.
- R3: With the master enable high and both channel enables set, both enables are 1. The main output's ideal activity is the reference; the complementary output's ideal activity is the inverted reference. Each output becomes active only when its ideal activity has been high at the current time and at no fewer than dt_i consecutive earlier rising edges. It becomes inactive in the same cycle its ideal activity drops. The level is activity XOR polarity.
- R4: In the mode of R3, the two outputs are never active at the same time.
- R5: In the mode of R3 with dt_i = 0, the complementary output's activity is the exact inverse of the main output's activity, with no gap.
- R6: With the master enable low, both enables are 0 and both levels are 0 when either the idle off-state select is 0 or both channel enables are 0.
- R7: With the master enable low, the idle off-state select at 1 and at least one channel enable set, both enables are 1 and each level equals its polarity bit. This holds from the moment the master enable drops, before any clock edge.
- R8: In the state of R7, each level changes to its idle-level bit once dt_i + 1 rising edges have occurred with the master enable low. Idle bits that make both outputs active together are not supported.
- R9: A high break input clears the master enable asynchronously and blocks writes while it is high. The master enable becomes 1 again only through a write with data 1 while break is low. A write with data 0 clears it.
- R10: During and right after reset the master enable is 0, so the outputs follow R6 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference compare waveform |
| brk_i | input | 1 | Break, active high, clears the master enable asynchronously |
| moe_wr_i | input | 1 | Write strobe for the master enable |
| moe_wdata_i | input | 1 | Value written to the master enable |
| ossr_i | input | 1 | Off-state select while running |
| ossi_i | input | 1 | Off-state select while idle |
| main_en_i | input | 1 | Main channel enable |
| comp_en_i | input | 1 | Complementary channel enable |
| main_pol_i | input | 1 | Main polarity (1 = active low) |
| comp_pol_i | input | 1 | Complementary polarity (1 = active low) |
| main_idle_i | input | 1 | Main idle level |
| comp_idle_i | input | 1 | Complementary idle level |
| dt_i | input | DT_W | Dead-time in clock cycles |
| main_o | output | 1 | Main output level |
| main_oe_o | output | 1 | Main output enable |
| comp_o | output | 1 | Complementary output level |
| comp_oe_o | output | 1 | Complementary output enable |

## Verification
The bench builds the block with the default 8-bit dead-time count. That width keeps settings of 0, a few cycles and several tens of cycles all within reach, so both the gapless case and long delays relative to the reference run lengths are covered. Dead-time values change while the waveform runs, and with the default width the run counters can saturate within a bounded test. The break input is raised between clock edges, so the asynchronous forcing is visible before any edge, and the idle timer is observed across its full dt + 1 edge window.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic [2:0] {
    MODE_NONE      = 3'd0,
    MODE_MAIN_ONLY = 3'd1,
    MODE_COMP_ONLY = 3'd2,
    MODE_PAIR      = 3'd3,
    MODE_SAFE      = 3'd4,
    MODE_OFF       = 3'd5
  } cpwm_mode_e;

  typedef struct packed {
    logic lvl;
    logic en;
  } pin_t;

  // Pick the output mapping from the master enable and control bits.
  function automatic cpwm_mode_e decode_mode(logic moe, logic ossi,
                                             logic ch, logic chn);
    cpwm_mode_e m;
    if (moe) begin
      unique case ({ch, chn})
        2'b11:   m = MODE_PAIR;
        2'b10:   m = MODE_MAIN_ONLY;
        2'b01:   m = MODE_COMP_ONLY;
        default: m = MODE_NONE;
      endcase
    end else if (ossi && (ch || chn)) begin
      m = MODE_SAFE;
    end else begin
      m = MODE_OFF;
    end
    return m;
  endfunction

  // Driven output: activity shaped by polarity.
  function automatic pin_t pin_drive(logic active, logic pol);
    pin_t p;
    p.lvl = active ^ pol;
    p.en  = 1'b1;
    return p;
  endfunction

  // Unused leg while running: parked inactive or released.
  function automatic pin_t pin_park(logic ossr, logic pol);
    pin_t p;
    p.lvl = ossr & pol;
    p.en  = ossr;
    return p;
  endfunction

  // Both legs unused while running: never driven.
  function automatic pin_t pin_float(logic ossr, logic pol);
    pin_t p;
    p.lvl = ossr & pol;
    p.en  = 1'b0;
    return p;
  endfunction

  // Safe state: inactive first, idle level once the timer expires.
  function automatic pin_t pin_safe(logic done, logic pol, logic idle);
    pin_t p;
    p.lvl = done ? idle : pol;
    p.en  = 1'b1;
    return p;
  endfunction

  // Saturating count step.
  function automatic logic [15:0] sat_step(logic [15:0] cur, logic [15:0] top);
    return (cur >= top) ? top : cur + 16'd1;
  endfunction

endpackage

// File: rtl/cpwm_moe_ctrl.sv
module cpwm_moe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic moe_o,
  output logic hold_clear_o
);

  logic moe_q;
  logic set_req;

  always_ff @(posedge clk or negedge rst_n or posedge brk_i) begin
    if (!rst_n) begin
      moe_q <= 1'b0;
    end else if (brk_i) begin
      moe_q <= 1'b0;
    end else if (wr_i) begin
      moe_q <= wdata_i;
    end
  end

  assign set_req      = wr_i & wdata_i & ~brk_i;
  assign moe_o        = moe_q;
  // The idle timer restarts whenever the enable is, or is about to be, high.
  assign hold_clear_o = moe_q | set_req;

  // R9
  brk_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |-> !moe_q);

  // R9
  moe_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moe_q) |-> $past(wr_i && wdata_i && !brk_i));

endmodule

// File: rtl/cpwm_idle_timer.sv
module cpwm_idle_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_clear_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            done_o
);
  import cpwm_pkg::*;

  localparam int CW = DT_W + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [15:0]   nxt;

  always_comb begin
    nxt = sat_step(16'(cnt_q), 16'(CMAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold_clear_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= nxt[CW-1:0];
    end
  end

  // Count of edges with the enable low exceeds the dead-time.
  assign done_o = cnt_q > {1'b0, dt_i};

  // R8
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !$past(hold_clear_i));

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  output logic [1:0]      act_o
);
  import cpwm_pkg::*;

  localparam int NLEG = 2;
  localparam logic [DT_W-1:0] RMAX = {DT_W{1'b1}};

  logic [NLEG-1:0] ideal;
  assign ideal = {~ref_i, ref_i};

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic [DT_W-1:0] run_q;
    logic [15:0]     step;

    always_comb begin
      step = sat_step(16'(run_q), 16'(RMAX));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= '0;
      end else if (!ideal[g]) begin
        run_q <= '0;
      end else begin
        run_q <= step[DT_W-1:0];
      end
    end

    // Assertion waits for the run length; release is immediate.
    assign act_o[g] = ideal[g] && (run_q >= dt_i);
  end

  // R4
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_o[0] && act_o[1]));

  // R5
  zero_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_i == '0) |-> (act_o[1] == !act_o[0]));

endmodule

// File: rtl/cpwm_out_map.sv
module cpwm_out_map (
  input  logic       moe_i,
  input  logic       ossr_i,
  input  logic       ossi_i,
  input  logic       main_en_i,
  input  logic       comp_en_i,
  input  logic       main_pol_i,
  input  logic       comp_pol_i,
  input  logic       main_idle_i,
  input  logic       comp_idle_i,
  input  logic       ref_i,
  input  logic [1:0] act_i,
  input  logic       idle_done_i,
  output cpwm_pkg::pin_t main_pin_o,
  output cpwm_pkg::pin_t comp_pin_o
);
  import cpwm_pkg::*;

  cpwm_mode_e mode;

  always_comb begin
    mode       = decode_mode(moe_i, ossi_i, main_en_i, comp_en_i);
    main_pin_o = '0;
    comp_pin_o = '0;
    unique case (mode)
      MODE_PAIR: begin
        main_pin_o = pin_drive(act_i[0], main_pol_i);
        comp_pin_o = pin_drive(act_i[1], comp_pol_i);
      end
      MODE_MAIN_ONLY: begin
        main_pin_o = pin_drive(ref_i, main_pol_i);
        comp_pin_o = pin_park(ossr_i, comp_pol_i);
      end
      MODE_COMP_ONLY: begin
        main_pin_o = pin_park(ossr_i, main_pol_i);
        comp_pin_o = pin_drive(ref_i, comp_pol_i);
      end
      MODE_NONE: begin
        main_pin_o = pin_float(ossr_i, main_pol_i);
        comp_pin_o = pin_float(ossr_i, comp_pol_i);
      end
      MODE_SAFE: begin
        main_pin_o = pin_safe(idle_done_i, main_pol_i, main_idle_i);
        comp_pin_o = pin_safe(idle_done_i, comp_pol_i, comp_idle_i);
      end
      default: begin
        main_pin_o = '0;
        comp_pin_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/cpwm_out_stage.sv
module cpwm_out_stage #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic            brk_i,
  input  logic            moe_wr_i,
  input  logic            moe_wdata_i,
  input  logic            ossr_i,
  input  logic            ossi_i,
  input  logic            main_en_i,
  input  logic            comp_en_i,
  input  logic            main_pol_i,
  input  logic            comp_pol_i,
  input  logic            main_idle_i,
  input  logic            comp_idle_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            main_o,
  output logic            main_oe_o,
  output logic            comp_o,
  output logic            comp_oe_o
);
  import cpwm_pkg::*;

  logic       moe;
  logic       hold_clear;
  logic       idle_done;
  logic [1:0] act;
  pin_t       main_pin;
  pin_t       comp_pin;

  cpwm_moe_ctrl u_moe (
    .clk          (clk),
    .rst_n        (rst_n),
    .brk_i        (brk_i),
    .wr_i         (moe_wr_i),
    .wdata_i      (moe_wdata_i),
    .moe_o        (moe),
    .hold_clear_o (hold_clear)
  );

  cpwm_idle_timer #(.DT_W(DT_W)) u_idle (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_clear_i (hold_clear),
    .dt_i         (dt_i),
    .done_o       (idle_done)
  );

  cpwm_deadtime #(.DT_W(DT_W)) u_dt (
    .clk   (clk),
    .rst_n (rst_n),
    .ref_i (ref_i),
    .dt_i  (dt_i),
    .act_o (act)
  );

  cpwm_out_map u_map (
    .moe_i       (moe),
    .ossr_i      (ossr_i),
    .ossi_i      (ossi_i),
    .main_en_i   (main_en_i),
    .comp_en_i   (comp_en_i),
    .main_pol_i  (main_pol_i),
    .comp_pol_i  (comp_pol_i),
    .main_idle_i (main_idle_i),
    .comp_idle_i (comp_idle_i),
    .ref_i       (ref_i),
    .act_i       (act),
    .idle_done_i (idle_done),
    .main_pin_o  (main_pin),
    .comp_pin_o  (comp_pin)
  );

  assign main_o    = main_pin.lvl;
  assign main_oe_o = main_pin.en;
  assign comp_o    = comp_pin.lvl;
  assign comp_oe_o = comp_pin.en;

  // R7
  safe_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe && ossi_i && (main_en_i || comp_en_i)) |-> (main_oe_o && comp_oe_o));

  // R2
  single_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moe && main_en_i && !comp_en_i) |-> (main_o == (ref_i ^ main_pol_i)));

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe && !ossi_i) |-> (!main_oe_o && !comp_oe_o));

  // R3
  pair_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moe && main_en_i && comp_en_i) |->
      !((main_o ^ main_pol_i) && (comp_o ^ comp_pol_i)));

endmodule

// File: tb/test_cpwm_out_stage.sv
module test_cpwm_out_stage;
  localparam int DT_W = 8;
  localparam int RUN_MAX  = (1 << DT_W) - 1;
  localparam int IDLE_MAX = (1 << (DT_W + 1)) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ref_s, brk, wr, wdata, ossr, ossi, men, cen, mpol, cpol, midle, cidle;
  logic [DT_W-1:0] dt;
  logic main_o, main_oe, comp_o, comp_oe;

  cpwm_out_stage #(.DT_W(DT_W)) i_cpwm_out_stage (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_s), .brk_i(brk),
    .moe_wr_i(wr), .moe_wdata_i(wdata), .ossr_i(ossr), .ossi_i(ossi),
    .main_en_i(men), .comp_en_i(cen), .main_pol_i(mpol), .comp_pol_i(cpol),
    .main_idle_i(midle), .comp_idle_i(cidle), .dt_i(dt),
    .main_o(main_o), .main_oe_o(main_oe), .comp_o(comp_o), .comp_oe_o(comp_oe)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  bit moe_m = 0;
  int hi_run = 0, lo_run = 0, low_edges = 0;

  task automatic cmp(string tag, string name, logic got, logic exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, name, got, exp, $time);
    end
  endtask

  task automatic check_now();
    bit eff;
    bit em, emo, ec, eco, a_m, a_c;
    string tag;
    eff = moe_m && !brk && rst_n;
    em = 0; emo = 0; ec = 0; eco = 0;
    if (!rst_n) tag = "R10";
    else if (brk) tag = "R9";
    else tag = "";
    if (eff) begin
      if (men && cen) begin
        a_m = ref_s && (hi_run >= int'(dt));
        a_c = !ref_s && (lo_run >= int'(dt));
        em = a_m ^ mpol; emo = 1;
        ec = a_c ^ cpol; eco = 1;
        if (tag == "") tag = (dt == 0) ? "R5" : "R3";
      end else if (men || cen) begin
        if (men) begin
          em = ref_s ^ mpol; emo = 1;
          ec = ossr & cpol;  eco = ossr;
        end else begin
          ec = ref_s ^ cpol; eco = 1;
          em = ossr & mpol;  emo = ossr;
        end
        if (tag == "") tag = "R2";
      end else begin
        em = ossr & mpol; ec = ossr & cpol;
        if (tag == "") tag = "R1";
      end
    end else if (ossi && (men || cen)) begin
      emo = 1; eco = 1;
      if (low_edges > int'(dt)) begin
        em = midle; ec = cidle;
        if (tag == "") tag = "R8";
      end else begin
        em = mpol; ec = cpol;
        if (tag == "") tag = "R7";
      end
    end else begin
      if (tag == "") tag = "R6";
    end
    vectors++;
    cmp(tag, "main_o", main_o, em);
    cmp(tag, "main_oe_o", main_oe, emo);
    cmp(tag, "comp_o", comp_o, ec);
    cmp(tag, "comp_oe_o", comp_oe, eco);
  endtask

  task automatic model_edge();
    bit eff, clr;
    if (!rst_n) begin
      moe_m = 0; hi_run = 0; lo_run = 0; low_edges = 0;
      return;
    end
    eff = moe_m && !brk;
    clr = eff || (wr && wdata && !brk);
    low_edges = clr ? 0 : ((low_edges < IDLE_MAX) ? low_edges + 1 : IDLE_MAX);
    hi_run = ref_s ? ((hi_run < RUN_MAX) ? hi_run + 1 : RUN_MAX) : 0;
    lo_run = !ref_s ? ((lo_run < RUN_MAX) ? lo_run + 1 : RUN_MAX) : 0;
    if (brk) moe_m = 0;
    else if (wr) moe_m = wdata;
  endtask

  task automatic tick();
    #1 check_now();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic write_moe(bit v);
    wr = 1; wdata = v; tick();
    wr = 0; wdata = 0;
  endtask

  task automatic run_ref(int n, int odds);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(odds - 1) == 0) ref_s = ~ref_s;
      tick();
    end
  endtask

  task automatic setup(bit m, bit c, bit pm, bit pc, bit r, bit s);
    men = m; cen = c; mpol = pm; cpol = pc; ossr = r; ossi = s;
  endtask

  task automatic legal_idle();
    midle = 1'($urandom_range(1)); cidle = 1'($urandom_range(1));
    if ((midle != mpol) && (cidle != cpol)) cidle = cpol;
    if (!men && !cen) begin mpol = 0; cpol = 0; midle = 0; cidle = 0; end
  endtask

  initial begin
    rst_n = 0; ref_s = 0; brk = 0; wr = 0; wdata = 0; dt = 0;
    setup(0, 0, 0, 0, 0, 0); midle = 0; cidle = 0;
    @(negedge clk);
    // R10: reset state
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1;
    tick();
    ossi = 1; men = 1; tick();   // R10 with safe state after reset
    ossi = 0; men = 0;

    // R3: pair mode with dead-time 3
    setup(1, 1, 0, 0, 0, 0); dt = 3;
    write_moe(1);
    run_ref(300, 6);
    mpol = 1; run_ref(150, 5);
    cpol = 1; run_ref(150, 4);
    mpol = 0; cpol = 0;

    // R5: zero dead-time
    dt = 0; run_ref(120, 2);
    // dead-time changes mid-waveform, long dead-time
    dt = 40; run_ref(400, 60);
    dt = 7; run_ref(100, 9);

    // R2: single channel, both off-state selects
    dt = 2;
    setup(1, 0, 0, 1, 0, 0); run_ref(60, 3);
    ossr = 1; run_ref(60, 3);
    setup(0, 1, 1, 0, 0, 0); run_ref(60, 3);
    ossr = 1; run_ref(60, 3);

    // R1: no channels
    setup(0, 0, 0, 0, 0, 0); run_ref(20, 3);
    ossr = 1; run_ref(20, 3);

    // R9, R7, R8: break, write blocked, idle after dt+1 edges
    setup(1, 1, 0, 0, 0, 1); midle = 1; cidle = 0; dt = 4;
    run_ref(20, 4);
    brk = 1; tick();
    wr = 1; wdata = 1; tick();
    wr = 0; wdata = 0; tick();
    brk = 0;
    for (int i = 0; i < 8; i++) tick();
    write_moe(1);
    run_ref(30, 4);
    write_moe(0);
    run_ref(10, 4);
    dt = 0; write_moe(1); write_moe(0); run_ref(4, 2);

    // R6: idle with off-state select clear, and with no channels
    ossi = 0; run_ref(10, 2);
    ossi = 1; men = 0; cen = 0; midle = 0; run_ref(10, 2);

    // Mixed random segments
    for (int seg = 0; seg < 120; seg++) begin
      men = 1'($urandom_range(1)); cen = 1'($urandom_range(1));
      mpol = 1'($urandom_range(1)); cpol = 1'($urandom_range(1));
      ossr = 1'($urandom_range(1)); ossi = 1'($urandom_range(1));
      legal_idle();
      dt = DT_W'($urandom_range(9));
      if ($urandom_range(3) == 0) begin brk = 1; tick(); brk = 0; end
      if ($urandom_range(2) == 0) write_moe(1'($urandom_range(3) != 0));
      run_ref(int'($urandom_range(25)) + 5, int'($urandom_range(5)) + 1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule